// File: doc/BRIEF.md
# Accumulator Multi-Bit Shift Unit

This block performs multi-bit shifts on the wide accumulator of a fixed-point DSP datapath. The accumulator is 56 bits wide and has three fields: an 8-bit guard byte at bits 55:48, a 24-bit upper word at bits 47:24 and a 24-bit lower word at bits 23:0. Five operations are offered. Two arithmetic shifts act on the whole accumulator. Two logical shifts act on the upper word alone. A normalize shift reads a signed count, and the sign of that count picks the direction.

Each request supplies an opcode, a shift count and the source accumulator. The count comes either from an immediate or from a 24-bit register operand. The shifted accumulator and an overflow flag are registered one clock after the request strobe, together with an output valid. Between requests the result stays on the outputs so the surrounding datapath can write it back whenever it is ready.

Top module: `acc_shift_unit`

## Requirements
- R1: Opcode `op` = 0 (arithmetic left) shifts all 56 bits left and fills with zeros from bit 0. With `use_imm`=1 the count is `imm[5:0]`; with `use_imm`=0 it is `reg_val[5:0]`. A count of 56 or more gives zero.
- R2: Opcode 1 (arithmetic right) shifts all 56 bits right and fills from the top with copies of bit 55. The count is chosen as in R1. A count of 56 or more gives 56 copies of the sign.
- R3: `ovf_out` is 1 after an arithmetic left shift (opcode 0, or opcode 4 with a positive count) exactly when some bit shifted out past bit 55 differs from bit 55 of the result. It is 0 after every other operation.
- R4: Opcode 2 (logical left) shifts bits 47:24 left and fills with zeros from bit 24. Bits 55:48 and bits 23:0 are passed through unchanged.
- R5: Opcode 3 (logical right) shifts bits 47:24 right and fills with zeros from bit 47. Bits 55:48 and bits 23:0 are passed through unchanged.
- R6: The count for a logical shift is `imm[4:0]` when `use_imm`=1, and `imm[5]` is ignored. It is `reg_val[4:0]` when `use_imm`=0. A count of 24 or more clears bits 47:24.
- R7: Opcode 4 (normalize) reads `reg_val` as a 24-bit two's complement value C and ignores both `use_imm` and `imm`. For C > 0 it performs an arithmetic left shift by C. For C < 0 it performs an arithmetic right shift by -C.
- R8: For normalize, the magnitude of the count is clamped to 55. C = 0 leaves the accumulator unchanged.
- R9: When `in_valid` is high at a clock edge, the result and `ovf_out` appear after that edge and `out_valid` is 1. At an edge where `in_valid` is low, `out_valid` goes to 0 and `acc_out` and `ovf_out` keep their values.
- R10: Synchronous reset `rst` clears `out_valid`, `acc_out` and `ovf_out` to zero.
- R11: Opcodes 5 to 7 copy `acc_in` to `acc_out` unchanged and set `ovf_out` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| op | input | 3 | Operation code (0 arith left, 1 arith right, 2 logical left, 3 logical right, 4 normalize) |
| use_imm | input | 1 | 1 selects the immediate count, 0 selects the register count |
| imm | input | 6 | Immediate shift count |
| reg_val | input | 24 | Register operand: the shift count, or the signed control value for normalize |
| acc_in | input | 56 | Source accumulator |
| out_valid | output | 1 | Result valid, one cycle after `in_valid` |
| acc_out | output | 56 | Registered destination accumulator |
| ovf_out | output | 1 | Overflow from an arithmetic left shift |

## Verification
An arithmetic left shift produces the shifted result and the overflow flag in the same cycle. The flag depends on exactly the bits the shift discards, so both outputs are judged together against a bit-serial model. The overflow is provoked at the edges of the condition: a single-bit shift that flips the sign, a shift of all ones out to zero, and a normalize left clamped to 55 that carries bit 0 to the sign. Back-to-back requests then check that each cycle's result and flag are replaced in full by the next request, and that neither is held over from the request before.

// File: rtl/acc_shift_pkg.sv
package acc_shift_pkg;
  typedef enum logic [2:0] {
    OP_ASL  = 3'd0,
    OP_ASR  = 3'd1,
    OP_LSL  = 3'd2,
    OP_LSR  = 3'd3,
    OP_NORM = 3'd4
  } shop_e;
endpackage

// File: rtl/acc_shift_amtdec.sv
// Works out the shift direction and the counts for each operation.
module acc_shift_amtdec
  import acc_shift_pkg::*;
#(
  parameter int ACC_W  = 56,
  parameter int REG_W  = 24,
  parameter int AMT_W  = 6,
  parameter int LAMT_W = 5
) (
  input  logic [2:0]        op,
  input  logic              use_imm,
  input  logic [AMT_W-1:0]  imm,
  input  logic [REG_W-1:0]  reg_val,
  output logic [AMT_W-1:0]  amt,
  output logic [LAMT_W-1:0] lamt,
  output logic              left
);
  localparam logic [AMT_W-1:0] CLAMP   = AMT_W'(ACC_W - 1);
  localparam logic [REG_W-1:0] CLAMP_W = REG_W'(ACC_W - 1);

  logic             neg;
  logic [REG_W-1:0] mag;

  always_comb begin
    neg = reg_val[REG_W-1];
    mag = neg ? (~reg_val + 1'b1) : reg_val;
  end

  always_comb begin
    amt  = use_imm ? imm : reg_val[AMT_W-1:0];
    lamt = use_imm ? imm[LAMT_W-1:0] : reg_val[LAMT_W-1:0];
    left = 1'b0;
    unique case (shop_e'(op))
      OP_ASL:  left = 1'b1;
      OP_LSL:  left = 1'b1;
      OP_NORM: begin
        left = ~neg;
        amt  = (mag > CLAMP_W) ? CLAMP : mag[AMT_W-1:0];
      end
      default: left = 1'b0;
    endcase
  end
endmodule

// File: rtl/acc_shift_arith.sv
// Full-width arithmetic shifter with overflow detection on left shifts.
module acc_shift_arith #(
  parameter int ACC_W = 56,
  parameter int AMT_W = 6
) (
  input  logic [ACC_W-1:0] acc,
  input  logic             left,
  input  logic [AMT_W-1:0] amt,
  output logic [ACC_W-1:0] res,
  output logic             ovf
);
  localparam int GUARD = (1 << AMT_W) - 1;
  localparam int WIDE  = ACC_W + GUARD;

  logic [WIDE-1:0]          wide;
  logic [GUARD:0]           top;
  logic signed [ACC_W-1:0]  sacc;
  logic [ACC_W-1:0]         rres;

  always_comb begin
    wide = {{GUARD{acc[ACC_W-1]}}, acc} << amt;
    top  = wide[WIDE-1:ACC_W-1];
    sacc = acc;
    rres = sacc >>> amt;
    res  = left ? wide[ACC_W-1:0] : rres;
    ovf  = left & ~((&top) | ~(|top));
  end
endmodule

// File: rtl/acc_shift_logic.sv
// Zero-fill shifter for a single word.
module acc_shift_logic #(
  parameter int WORD_W = 24,
  parameter int LAMT_W = 5
) (
  input  logic [WORD_W-1:0] word,
  input  logic              left,
  input  logic [LAMT_W-1:0] amt,
  output logic [WORD_W-1:0] res
);
  always_comb begin
    res = left ? (word << amt) : (word >> amt);
  end
endmodule

// File: rtl/acc_shift_unit.sv
module acc_shift_unit
  import acc_shift_pkg::*;
#(
  parameter int EXT_W  = 8,
  parameter int WORD_W = 24,
  parameter int AMT_W  = 6,
  parameter int LAMT_W = 5
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        in_valid,
  input  logic [2:0]                  op,
  input  logic                        use_imm,
  input  logic [AMT_W-1:0]            imm,
  input  logic [WORD_W-1:0]           reg_val,
  input  logic [EXT_W+2*WORD_W-1:0]   acc_in,
  output logic                        out_valid,
  output logic [EXT_W+2*WORD_W-1:0]   acc_out,
  output logic                        ovf_out
);
  localparam int ACC_W  = EXT_W + 2 * WORD_W;
  localparam int HI_LSB = WORD_W;
  localparam int HI_MSB = 2 * WORD_W - 1;

  logic [AMT_W-1:0]  amt;
  logic [LAMT_W-1:0] lamt;
  logic              left;
  logic [ACC_W-1:0]  ares;
  logic              aovf;
  logic [WORD_W-1:0] lres;
  logic [ACC_W-1:0]  nxt;
  logic              nxt_ovf;

  acc_shift_amtdec #(
    .ACC_W(ACC_W), .REG_W(WORD_W), .AMT_W(AMT_W), .LAMT_W(LAMT_W)
  ) u_dec (
    .op(op), .use_imm(use_imm), .imm(imm), .reg_val(reg_val),
    .amt(amt), .lamt(lamt), .left(left)
  );

  acc_shift_arith #(.ACC_W(ACC_W), .AMT_W(AMT_W)) u_arith (
    .acc(acc_in), .left(left), .amt(amt), .res(ares), .ovf(aovf)
  );

  acc_shift_logic #(.WORD_W(WORD_W), .LAMT_W(LAMT_W)) u_logic (
    .word(acc_in[HI_MSB:HI_LSB]), .left(left), .amt(lamt), .res(lres)
  );

  always_comb begin
    nxt     = acc_in;
    nxt_ovf = 1'b0;
    unique case (shop_e'(op))
      OP_ASL, OP_ASR, OP_NORM: begin
        nxt     = ares;
        nxt_ovf = aovf;
      end
      OP_LSL, OP_LSR: nxt = {acc_in[ACC_W-1:HI_MSB+1], lres, acc_in[HI_LSB-1:0]};
      default: begin
        nxt     = acc_in;
        nxt_ovf = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      acc_out   <= '0;
      ovf_out   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        acc_out <= nxt;
        ovf_out <= nxt_ovf;
      end
    end
  end
endmodule

// File: rtl/acc_shift_chk.sv
module acc_shift_chk #(
  parameter int EXT_W  = 8,
  parameter int WORD_W = 24,
  parameter int AMT_W  = 6
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      in_valid,
  input logic [2:0]                op,
  input logic [WORD_W-1:0]         reg_val,
  input logic [EXT_W+2*WORD_W-1:0] acc_in,
  input logic                      out_valid,
  input logic [EXT_W+2*WORD_W-1:0] acc_out,
  input logic                      ovf_out
);
  localparam int ACC_W = EXT_W + 2 * WORD_W;

  // R10
  a_r10_reset_clear: assert property (@(posedge clk)
    rst |=> (!out_valid && acc_out == '0 && !ovf_out));

  // R9
  a_r9_valid_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  a_r9_valid_drops: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(acc_out) && $stable(ovf_out)));

  // R4 and R5: guard byte and lower word pass through on logical shifts
  a_r4_r5_fields_kept: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (op == 3'd2 || op == 3'd3)) |=>
    (acc_out[ACC_W-1:2*WORD_W] == $past(acc_in[ACC_W-1:2*WORD_W]) &&
     acc_out[WORD_W-1:0] == $past(acc_in[WORD_W-1:0])));

  // R3: right and logical shifts never flag overflow
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op >= 3'd1 && op <= 3'd3) |=> !ovf_out);

  // R8
  a_r8_norm_zero: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 3'd4 && reg_val == '0) |=>
    (acc_out == $past(acc_in) && !ovf_out));

  // R11
  a_r11_pass: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op >= 3'd5) |=> (acc_out == $past(acc_in) && !ovf_out));
endmodule

bind acc_shift_unit acc_shift_chk #(
  .EXT_W(EXT_W), .WORD_W(WORD_W), .AMT_W(AMT_W)
) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .reg_val(reg_val),
  .acc_in(acc_in), .out_valid(out_valid), .acc_out(acc_out), .ovf_out(ovf_out)
);

// File: tb/acc_shift_unit_bench.sv
module acc_shift_unit_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [2:0]  op = '0;
  logic        use_imm = 1'b0;
  logic [5:0]  imm = '0;
  logic [23:0] reg_val = '0;
  logic [55:0] acc_in = '0;
  logic        out_valid;
  logic [55:0] acc_out;
  logic        ovf_out;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  acc_shift_unit u_acc_shift_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .use_imm(use_imm),
    .imm(imm), .reg_val(reg_val), .acc_in(acc_in), .out_valid(out_valid),
    .acc_out(acc_out), .ovf_out(ovf_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [55:0] got, input logic [55:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // Bit-serial reference built from the requirements.
  task automatic model(input logic [2:0] mop, input logic ui, input logic [5:0] im,
                       input logic [23:0] rv, input logic [55:0] a,
                       output logic [55:0] r, output logic o);
    int n;
    int cv;
    logic any1, any0;
    logic [23:0] h;
    bit lft;
    r = a; o = 1'b0; any1 = 1'b0; any0 = 1'b0; h = a[47:24]; n = 0; lft = 0;
    case (mop)
      3'd0: begin n = ui ? int'(im) : int'(rv[5:0]); lft = 1; end
      3'd1: begin n = ui ? int'(im) : int'(rv[5:0]); lft = 0; end
      3'd4: begin
        cv = int'($signed(rv));
        lft = (cv > 0);
        n = (cv < 0) ? -cv : cv;
        if (n > 55) n = 55;
      end
      default: n = 0;
    endcase
    if (mop == 3'd0 || mop == 3'd1 || mop == 3'd4) begin
      for (int i = 0; i < n; i++) begin
        if (lft) begin
          if (r[55]) any1 = 1'b1; else any0 = 1'b1;
          r = {r[54:0], 1'b0};
        end else begin
          r = {r[55], r[55:1]};
        end
      end
      if (lft) o = r[55] ? any0 : any1;
    end else if (mop == 3'd2 || mop == 3'd3) begin
      n = ui ? int'(im[4:0]) : int'(rv[4:0]);
      for (int i = 0; i < n; i++)
        h = (mop == 3'd2) ? {h[22:0], 1'b0} : {1'b0, h[23:1]};
      r[47:24] = h;
    end
  endtask

  task automatic run_op(input string tag, input logic [2:0] o_, input logic ui,
                        input logic [5:0] im, input logic [23:0] rv, input logic [55:0] a);
    logic [55:0] er;
    logic eo;
    model(o_, ui, im, rv, a, er, eo);
    @(negedge clk);
    op = o_; use_imm = ui; imm = im; reg_val = rv; acc_in = a; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk({tag, " R9 valid"}, {55'd0, out_valid}, 56'd1);
    chk({tag, " acc"}, acc_out, er);
    chk({tag, " ovf R3"}, {55'd0, ovf_out}, {55'd0, eo});
  endtask

  task automatic t_reset();
    chk("R10 valid", {55'd0, out_valid}, 56'd0);
    chk("R10 acc", acc_out, 56'd0);
    chk("R10 ovf", {55'd0, ovf_out}, 56'd0);
  endtask

  task automatic t_asl();
    run_op("R1 imm4", 3'd0, 1'b1, 6'd4, 24'd0, 56'h00_123456_789ABC);
    run_op("R1 reg low6", 3'd0, 1'b0, 6'd0, 24'hFFFF48, 56'h00_00F0F0_0F0F0F);
    run_op("R1 zero count", 3'd0, 1'b1, 6'd0, 24'd0, 56'h9A_BCDEF0_123456);
    run_op("R3 sign flip", 3'd0, 1'b1, 6'd1, 24'd0, 56'h40_000000_000000);
    run_op("R3 ones out R1 63", 3'd0, 1'b1, 6'd63, 24'd0, 56'hFF_FFFFFF_FFFFFF);
    run_op("R3 neg no ovf", 3'd0, 1'b1, 6'd3, 24'd0, 56'hF0_000000_000001);
  endtask

  task automatic t_asr();
    run_op("R2 imm12", 3'd1, 1'b1, 6'd12, 24'd0, 56'h80_123456_789ABC);
    run_op("R2 reg pos", 3'd1, 1'b0, 6'd0, 24'h000007, 56'h7F_FFFFFF_FFFF00);
    run_op("R2 count60", 3'd1, 1'b1, 6'd60, 24'd0, 56'h80_000000_000000);
  endtask

  task automatic t_logic();
    run_op("R4 R6 imm bit5", 3'd2, 1'b1, 6'b100011, 24'd0, 56'hA5_C00001_5A5A5A);
    run_op("R4 R6 reg26", 3'd2, 1'b0, 6'd0, 24'hFFFFFA, 56'hA5_FFFFFF_5A5A5A);
    run_op("R5 imm5", 3'd3, 1'b1, 6'd5, 24'd0, 56'hFF_800001_FFFFFF);
    run_op("R5 R6 reg31", 3'd3, 1'b0, 6'd0, 24'h00001F, 56'h12_FFFFFF_345678);
  endtask

  task automatic t_norm();
    run_op("R7 pos5 imm ignored", 3'd4, 1'b1, 6'd40, 24'd5, 56'h00_0ABCDE_F01234);
    run_op("R7 neg7", 3'd4, 1'b0, 6'd0, 24'hFFFFF9, 56'hC0_123456_789ABC);
    run_op("R8 zero", 3'd4, 1'b1, 6'd9, 24'd0, 56'h87_654321_0FEDCB);
    run_op("R8 clamp neg", 3'd4, 1'b0, 6'd0, 24'h800000, 56'h80_000000_000001);
    run_op("R8 clamp pos R3", 3'd4, 1'b0, 6'd0, 24'd100, 56'h00_000000_000001);
  endtask

  task automatic t_illegal();
    run_op("R11 op5", 3'd5, 1'b1, 6'd7, 24'd3, 56'h11_223344_556677);
    run_op("R11 op7", 3'd7, 1'b0, 6'd0, 24'd9, 56'hFF_000000_000000);
  endtask

  task automatic t_hold();
    logic [55:0] keep;
    run_op("R9 pre", 3'd0, 1'b1, 6'd1, 24'd0, 56'h40_000000_000000);
    keep = acc_out;
    op = 3'd1; acc_in = 56'h0; imm = 6'd3;
    repeat (3) @(negedge clk);
    chk("R9 idle valid", {55'd0, out_valid}, 56'd0);
    chk("R9 idle acc", acc_out, keep);
    chk("R9 idle ovf", {55'd0, ovf_out}, 56'd1);
  endtask

  task automatic t_b2b();
    logic [55:0] r1, r2;
    logic o1, o2;
    model(3'd0, 1'b1, 6'd1, 24'd0, 56'h40_000000_000000, r1, o1);
    model(3'd1, 1'b1, 6'd4, 24'd0, 56'h80_000000_0000F0, r2, o2);
    @(negedge clk);
    op = 3'd0; use_imm = 1'b1; imm = 6'd1; acc_in = 56'h40_000000_000000; in_valid = 1'b1;
    @(negedge clk);
    op = 3'd1; imm = 6'd4; acc_in = 56'h80_000000_0000F0;
    chk("R9 b2b first acc", acc_out, r1);
    chk("R3 b2b first ovf", {55'd0, ovf_out}, {55'd0, o1});
    @(negedge clk);
    in_valid = 1'b0;
    chk("R9 b2b second valid", {55'd0, out_valid}, 56'd1);
    chk("R2 b2b second acc", acc_out, r2);
    chk("R3 b2b second ovf", {55'd0, ovf_out}, {55'd0, o2});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    t_asl();
    t_asr();
    t_logic();
    t_norm();
    t_illegal();
    t_hold();
    t_b2b();
    @(negedge clk);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule